// File: doc/BRIEF.md
# Radio MAC Period Timer

This block is the timekeeper of a low-rate wireless MAC layer. A 16-bit counter advances once per system clock while the timer runs. When the count would reach a programmable period, it wraps to the overshoot rather than to zero, so no cycles are lost if the period is moved below the current count. Writing a delta value stretches the current period: the main counter freezes while a down-counter drains the delta. An 8-bit compare watches either byte of the count. A 20-bit counter totals period wraps and has its own match compare.

Software uses a simple registered write port. It sets the run bit, the start/stop alignment mode, the compare byte select, the interrupt masks, the period, the delta, the compare value and the wrap-count compare value. It also clears event flags. Start and stop can take effect on the next clock or wait for a rising edge of a slow 32 kHz reference. That reference is synchronised into the system clock domain inside the block. Each event source drives a sticky flag, a masked interrupt request and a one-cycle DMA trigger.

Top module: `mac_period_timer`

## Requirements
- R1: After reset, the count, the wrap count, the flags, the DMA pulses and the running indication are all zero, every write register is zero, and the timer is stopped.
- R2: The write address map is: 0 control, 1 period, 2 delta, 3 compare value, 4 wrap-count compare, 5 flag clear. The control fields are: bit 0 run, bit 1 align-to-reference, bit 2 high-byte select, bits 5:3 interrupt masks. With bit 1 at 0, `running_o` takes the run bit's value one clock after the control write is registered.
- R3: With bit 1 at 1, `running_o` changes only in response to a rising edge of `ref_clk_i`. If the reference is first sampled high at clock edge N after being low, `running_o` takes the run bit at edge N+2.
- R4: While running with the delta counter at zero, the count increases by one per clock. While stopped, the count holds its value.
- R5: If the incremented count is greater than or equal to the period, the count becomes the incremented value minus the period, and a period event (source 1) occurs. A period of P therefore yields counts 0..P-1.
- R6: A delta write loads the delta down-counter. While that counter is non-zero and the timer runs, it decrements each clock and the count holds. Once it is at zero, it stays at zero until the next delta write.
- R7: A compare event (source 0) occurs on a counting step when the selected byte of the new count is at least the compare value and the selected byte of the old count was below it. Control bit 2 at 1 selects bits 15:8; at 0 it selects bits 7:0.
- R8: The wrap count increases by one (modulo 2^20) on each period event. A wrap-compare event (source 2) occurs when the new wrap count equals the wrap-count compare register.
- R9: An event sets its flag bit in `flag_o` at the same edge. The bit stays set until a write to address 5 with that data bit at 0. A new event in the same cycle wins over the clear.
- R10: `irq_o[i]` is `flag_o[i]` and mask bit i (control bit 3+i).
- R11: `dma_o[i]` is high for exactly the one cycle after the edge at which event i occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | 32 kHz reference, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 20 | Register write data |
| running_o | output | 1 | Timer is in RUN mode |
| count_o | output | 16 | Main counter value |
| ovf_count_o | output | 20 | Period wrap count |
| flag_o | output | 3 | Sticky event flags (0 compare, 1 period, 2 wrap compare) |
| irq_o | output | 3 | Masked interrupt requests |
| dma_o | output | 3 | One-cycle DMA trigger per event source |

## Verification
The assertions assume that `ref_clk_i` is a slow signal that holds each level for several system clocks, so that the synchroniser sees every edge once. They also assume that all register changes arrive through the write port while reset is inactive. The stimulus toggles the reference every six clocks and drives writes only away from the active edge. Periods stay in a small range so that wraps, compare crossings and wrap-count matches happen often. Deltas, stops, alignment-mode changes and flag clears are mixed in at random.

// File: rtl/mpt_pkg.sv
package mpt_pkg;

  localparam int unsigned ADDR_W = 3;
  localparam int unsigned N_SRC  = 3;

  localparam int unsigned SRC_CMP = 0;
  localparam int unsigned SRC_PER = 1;
  localparam int unsigned SRC_OVC = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL    = 3'd0,
    A_PERIOD  = 3'd1,
    A_DELTA   = 3'd2,
    A_CMP     = 3'd3,
    A_OVC_CMP = 3'd4,
    A_FLAGS   = 3'd5
  } mpt_addr_e;

  localparam int unsigned CTRL_W = 3 + N_SRC;

  typedef struct packed {
    logic [N_SRC-1:0] mask;
    logic             cmp_hi;
    logic             align_ref;
    logic             run;
  } mpt_ctrl_t;

endpackage

// File: rtl/mpt_ref_sync.sv
module mpt_ref_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_i,
  output logic rise_o
);

  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], ref_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/mpt_run_ctrl.sv
module mpt_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic run_req_i,
  input  logic align_ref_i,
  input  logic ref_rise_i,
  output logic running_o
);

  logic running_q;
  logic running_d;
  logic upd_en;

  always_comb begin
    upd_en    = !align_ref_i || ref_rise_i;
    running_d = upd_en ? run_req_i : running_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) running_q <= 1'b0;
    else        running_q <= running_d;
  end

  assign running_o = running_q;

  // R2
  imm_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !align_ref_i |=> running_q == $past(run_req_i));

  // R3
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (align_ref_i && !ref_rise_i) |=> $stable(running_q));

endmodule

// File: rtl/mpt_count_core.sv
module mpt_count_core #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned CMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CMP_W-1:0] cmp_val_i,
  input  logic             cmp_hi_i,
  input  logic             delta_wr_i,
  input  logic [CNT_W-1:0] delta_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             per_evt_o,
  output logic             cmp_evt_o
);

  localparam int unsigned EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] count_q, count_d;
  logic [CNT_W-1:0] delta_q, delta_d;
  logic [EXT_W-1:0] inc_ext;
  logic [EXT_W-1:0] diff_ext;
  logic [CNT_W-1:0] stepped;
  logic             wrap;
  logic             step_en;
  logic             delta_busy;

  function automatic logic byte_ge(input logic [CNT_W-1:0] v,
                                   input logic             hi,
                                   input logic [CMP_W-1:0] c);
    logic [CMP_W-1:0] b;
    b = hi ? v[CNT_W-1 -: CMP_W] : v[CMP_W-1:0];
    return b >= c;
  endfunction

  always_comb begin
    delta_busy = (delta_q != '0);
    step_en    = running_i && !delta_busy;
    inc_ext    = {1'b0, count_q} + EXT_W'(1);
    diff_ext   = inc_ext - {1'b0, period_i};
    wrap       = inc_ext >= {1'b0, period_i};
    stepped    = wrap ? diff_ext[CNT_W-1:0] : inc_ext[CNT_W-1:0];

    count_d = count_q;
    if (step_en) count_d = stepped;

    delta_d = delta_q;
    if (delta_wr_i)                   delta_d = delta_val_i;
    else if (running_i && delta_busy) delta_d = delta_q - CNT_W'(1);

    per_evt_o = step_en && wrap;
    cmp_evt_o = step_en && byte_ge(stepped, cmp_hi_i, cmp_val_i)
                        && !byte_ge(count_q, cmp_hi_i, cmp_val_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      delta_q <= '0;
    end else begin
      count_q <= count_d;
      delta_q <= delta_d;
    end
  end

  assign count_o = count_q;

  // R4
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running_i |=> $stable(count_q));

  // R6
  delta_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (delta_q != '0) |=> $stable(count_q));

  // R6
  delta_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (delta_q == '0 && !delta_wr_i) |=> delta_q == '0);

endmodule

// File: rtl/mpt_ovf_counter.sv
module mpt_ovf_counter #(
  parameter int unsigned OVF_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             per_evt_i,
  input  logic [OVF_W-1:0] ovc_cmp_i,
  output logic [OVF_W-1:0] ovc_o,
  output logic             ovc_evt_o
);

  logic [OVF_W-1:0] ovc_q, ovc_d;
  logic [OVF_W-1:0] ovc_inc;

  always_comb begin
    ovc_inc   = ovc_q + OVF_W'(1);
    ovc_d     = per_evt_i ? ovc_inc : ovc_q;
    ovc_evt_o = per_evt_i && (ovc_inc == ovc_cmp_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovc_q <= '0;
    else        ovc_q <= ovc_d;
  end

  assign ovc_o = ovc_q;

  // R8
  ovc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_evt_i |=> ovc_q == $past(ovc_q) + OVF_W'(1));

  // R8
  ovc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !per_evt_i |=> $stable(ovc_q));

endmodule

// File: rtl/mpt_evt_bank.sv
module mpt_evt_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         clr_wr_i,
  input  logic [N-1:0] keep_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] irq_o,
  output logic [N-1:0] dma_o
);

  for (genvar g = 0; g < N; g++) begin : g_src
    logic flag_q, flag_d;
    logic dma_q;

    always_comb begin
      flag_d = flag_q;
      if (clr_wr_i && !keep_i[g]) flag_d = 1'b0;
      if (evt_i[g])               flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q <= 1'b0;
        dma_q  <= 1'b0;
      end else begin
        flag_q <= flag_d;
        dma_q  <= evt_i[g];
      end
    end

    assign flag_o[g] = flag_q;
    assign dma_o[g]  = dma_q;
    assign irq_o[g]  = flag_q & mask_i[g];

    // R9
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[g] |=> flag_q);

    // R11
    dma_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_q |-> flag_q);
  end

endmodule

// File: rtl/mac_period_timer.sv
module mac_period_timer
  import mpt_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned CMP_W       = 8,
  parameter int unsigned OVF_W       = 20,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned DATA_W     = (OVF_W > CNT_W) ? OVF_W : CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              running_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [OVF_W-1:0]  ovf_count_o,
  output logic [N_SRC-1:0]  flag_o,
  output logic [N_SRC-1:0]  irq_o,
  output logic [N_SRC-1:0]  dma_o
);

  mpt_ctrl_t        ctrl_q, ctrl_d;
  logic [CNT_W-1:0] period_q, period_d;
  logic [CMP_W-1:0] cmp_q, cmp_d;
  logic [OVF_W-1:0] ovc_cmp_q, ovc_cmp_d;
  logic             delta_wr;
  logic             clr_wr;
  logic             ref_rise;
  logic             per_evt, cmp_evt, ovc_evt;
  logic [N_SRC-1:0] evt_vec;

  always_comb begin
    ctrl_d    = ctrl_q;
    period_d  = period_q;
    cmp_d     = cmp_q;
    ovc_cmp_d = ovc_cmp_q;
    delta_wr  = 1'b0;
    clr_wr    = 1'b0;
    if (wr_en_i) begin
      case (wr_addr_i)
        A_CTRL:    ctrl_d    = mpt_ctrl_t'(wr_data_i[CTRL_W-1:0]);
        A_PERIOD:  period_d  = wr_data_i[CNT_W-1:0];
        A_DELTA:   delta_wr  = 1'b1;
        A_CMP:     cmp_d     = wr_data_i[CMP_W-1:0];
        A_OVC_CMP: ovc_cmp_d = wr_data_i[OVF_W-1:0];
        A_FLAGS:   clr_wr    = 1'b1;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      period_q  <= '0;
      cmp_q     <= '0;
      ovc_cmp_q <= '0;
    end else begin
      ctrl_q    <= ctrl_d;
      period_q  <= period_d;
      cmp_q     <= cmp_d;
      ovc_cmp_q <= ovc_cmp_d;
    end
  end

  mpt_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .ref_i  (ref_clk_i),
    .rise_o (ref_rise)
  );

  mpt_run_ctrl u_run (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_req_i   (ctrl_q.run),
    .align_ref_i (ctrl_q.align_ref),
    .ref_rise_i  (ref_rise),
    .running_o   (running_o)
  );

  mpt_count_core #(.CNT_W(CNT_W), .CMP_W(CMP_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .running_i   (running_o),
    .period_i    (period_q),
    .cmp_val_i   (cmp_q),
    .cmp_hi_i    (ctrl_q.cmp_hi),
    .delta_wr_i  (delta_wr),
    .delta_val_i (wr_data_i[CNT_W-1:0]),
    .count_o     (count_o),
    .per_evt_o   (per_evt),
    .cmp_evt_o   (cmp_evt)
  );

  mpt_ovf_counter #(.OVF_W(OVF_W)) u_ovc (
    .clk       (clk),
    .rst_n     (rst_n),
    .per_evt_i (per_evt),
    .ovc_cmp_i (ovc_cmp_q),
    .ovc_o     (ovf_count_o),
    .ovc_evt_o (ovc_evt)
  );

  always_comb begin
    evt_vec          = '0;
    evt_vec[SRC_CMP] = cmp_evt;
    evt_vec[SRC_PER] = per_evt;
    evt_vec[SRC_OVC] = ovc_evt;
  end

  mpt_evt_bank #(.N(N_SRC)) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_vec),
    .clr_wr_i (clr_wr),
    .keep_i   (wr_data_i[N_SRC-1:0]),
    .mask_i   (ctrl_q.mask),
    .flag_o   (flag_o),
    .irq_o    (irq_o),
    .dma_o    (dma_o)
  );

  // R5
  wrap_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_evt |=> ovf_count_o != $past(ovf_count_o));

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~ctrl_q.mask) == '0);

endmodule

// File: tb/mac_period_timer_tb_top.sv
`timescale 1ns/1ps
module mac_period_timer_tb_top;

  localparam int REF_HALF = 6;
  localparam int WDOG_CYC = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ref_clk;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [19:0] wr_data;
  logic        running;
  logic [15:0] count;
  logic [19:0] ovf_count;
  logic [2:0]  flag, irq, dma;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;
  int refcnt = 0;
  int last_rise = -100;

  always #2.5 clk = ~clk;

  mac_period_timer dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_clk_i   (ref_clk),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .running_o   (running),
    .count_o     (count),
    .ovf_count_o (ovf_count),
    .flag_o      (flag),
    .irq_o       (irq),
    .dma_o       (dma)
  );

  // reference model state
  logic        m_run;
  logic [5:0]  m_ctrl;
  logic [15:0] m_per, m_cnt, m_dlt;
  logic [7:0]  m_cmp;
  logic [19:0] m_ovcc, m_ovc, t_ovn;
  logic [2:0]  m_flag, m_dma, m_s, t_ev;
  logic [16:0] t_nx;
  logic [15:0] t_st;
  logic        t_rise, t_step, t_wrap, t_newrun;

  function automatic logic sel_ge(input logic [15:0] v, input logic hi, input logic [7:0] c);
    logic [7:0] b;
    b = hi ? v[15:8] : v[7:0];
    return b >= c;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_ctrl = 0; m_per = 0; m_cnt = 0; m_dlt = 0; m_cmp = 0;
      m_ovcc = 0; m_ovc = 0; m_flag = 0; m_dma = 0; m_s = 0;
    end else begin
      t_rise = m_s[1] & ~m_s[2];
      m_s    = {m_s[1:0], ref_clk};
      t_step = m_run && (m_dlt == 0);
      t_nx   = {1'b0, m_cnt} + 17'd1;
      t_wrap = t_nx >= {1'b0, m_per};
      t_st   = t_wrap ? 16'(t_nx - {1'b0, m_per}) : t_nx[15:0];
      t_ev   = 3'b000;
      if (t_step) begin
        t_ev[1] = t_wrap;
        t_ev[0] = sel_ge(t_st, m_ctrl[2], m_cmp) && !sel_ge(m_cnt, m_ctrl[2], m_cmp);
      end
      t_ovn = m_ovc + 20'd1;
      if (t_ev[1]) t_ev[2] = (t_ovn == m_ovcc);
      t_newrun = m_ctrl[1] ? (t_rise ? m_ctrl[0] : m_run) : m_ctrl[0];
      if (t_step) m_cnt = t_st;
      if (wr_en && wr_addr == 3'd2) m_dlt = wr_data[15:0];
      else if (m_run && m_dlt != 0) m_dlt = m_dlt - 16'd1;
      if (t_ev[1]) m_ovc = t_ovn;
      m_flag = ((wr_en && wr_addr == 3'd5) ? (m_flag & wr_data[2:0]) : m_flag) | t_ev;
      m_dma  = t_ev;
      m_run  = t_newrun;
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_ctrl = wr_data[5:0];
          3'd1: m_per  = wr_data[15:0];
          3'd3: m_cmp  = wr_data[7:0];
          3'd4: m_ovcc = wr_data;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    chk("R2/R3 running", running, m_run);
    chk("R5 count", count, m_cnt);
    chk("R8 wrap count", ovf_count, m_ovc);
    chk("R9 flags", flag, m_flag);
    chk("R10 irq", irq, m_flag & m_ctrl[5:3]);
    chk("R11 dma", dma, m_dma);
    refcnt++;
    if (refcnt == REF_HALF) begin
      refcnt  = 0;
      ref_clk = ~ref_clk;
      if (ref_clk) last_rise = cyc;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [19:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic wait_count(input int unsigned v);
    for (int i = 0; i < 2000 && count != v; i++) tick();
  endtask

  initial begin
    #(WDOG_CYC * 5.0);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int unsigned c0;
    int unsigned r;
    void'($urandom(32'd4242));
    rst_n = 0; ref_clk = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 wrap count", ovf_count, 0);
    chk("R1 flags", flag, 0);
    chk("R1 running", running, 0);
    chk("R1 dma", dma, 0);
    rst_n = 1;
    tick();

    wr(3'd1, 20'd300);
    wr(3'd3, 20'd20);
    // R2: immediate start, running one clock after the control register
    wr(3'd0, 20'h39);
    chk("R2 running after write", running, 0);
    tick();
    chk("R2 running next clock", running, 1);

    // R7 compare crossing on the low byte
    wait_count(19);
    chk("R7 flag before cross", flag[0], 0);
    tick();
    chk("R7 count at cross", count, 20);
    chk("R7 flag after cross", flag[0], 1);
    chk("R11 dma at cross", dma[0], 1);
    chk("R10 irq at cross", irq[0], 1);
    tick();
    chk("R11 dma one cycle", dma[0], 0);

    // R5 overshoot wrap when period drops below count
    wait_count(100);
    c0 = count;
    wr(3'd1, 20'd50);
    chk("R4 step", count, c0 + 1);
    tick();
    chk("R5 overshoot", count, c0 + 2 - 50);
    chk("R8 wrap count step", ovf_count, 1);

    // R6 delta stretch
    wait_count(10);
    wr(3'd2, 20'd5);
    chk("R6 step at write", count, 11);
    repeat (5) tick();
    chk("R6 frozen", count, 11);
    tick();
    chk("R6 resume", count, 12);

    // R9 clear only the period flag
    wr(3'd5, 20'b101);
    chk("R9 cleared bit", flag[1], 0);
    chk("R9 kept bit", flag[0], 1);

    // R4 stop holds count
    wr(3'd0, 20'h38);
    tick();
    c0 = count;
    repeat (10) tick();
    chk("R4 stopped hold", count, c0);
    chk("R2 stopped", running, 0);

    // R3 aligned start
    wr(3'd0, 20'h3B);
    for (int i = 0; i < 60 && !running; i++) tick();
    chk("R3 aligned start latency", cyc - last_rise, 3);

    // random phase
    for (int i = 0; i < 20000; i++) begin
      r = $urandom % 100;
      if (r < 6) begin
        case ($urandom % 6)
          0: wr(3'd0, {14'd0, 3'($urandom % 8), 1'($urandom % 2),
                       1'(($urandom % 4) == 0), 1'(($urandom % 10) != 0)});
          1: wr(3'd1, 20'(8 + $urandom % 300));
          2: wr(3'd2, 20'($urandom % 20));
          3: wr(3'd3, 20'($urandom % 256));
          4: wr(3'd4, 20'($urandom % 32));
          default: wr(3'd5, 20'($urandom % 8));
        endcase
      end else begin
        tick();
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule